// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Interface Sequencer

This block models the digital control of a multi-channel delta-sigma converter. It runs a fixed loop with no configuration registers. After a power-on wait it converts, then sleeps, then hands the result to a host over a serial link, and then converts again. The analog conversion is replaced by a cycle counter. The result value comes from a parallel input, which is captured when the counter expires.

The host drives three pins that have no timing relation to the system clock: an active-low chip select, a serial clock and a serial data input. Each pin passes through a two-flop synchronizer, and the serial clock edges are found on the synchronized copy. Pulling chip select low while the block sleeps starts the readout. The 32-bit result leaves most significant bit first, and at the same time an 8-bit channel address is shifted in. The address selects the channel for the conversion after this one. Raising chip select early cuts the readout short and starts the next conversion at once.

Top module: `adc_serial_sequencer`

## Requirements
- R1: Once the power-on wait ends, `convActive` stays high for CONV_CYCLES clocks. It then drops (sleep), and the block stays in sleep for as long as `csN` is high.
- R2: `csN` low during sleep starts the readout. The result's most significant bit (bit 31) is on `sdo` before the first `sck` edge.
- R3: `sdo` moves to the next lower result bit only after a falling edge of `sck`. It holds steady while `sck` is high.
- R4: If `csN` goes high before the readout completes, the readout ends and a new conversion starts (`convActive` high).
- R5: After the 32nd falling edge of `sck`, a new conversion starts with no other host action.
- R6: `sdi` is sampled on the first 8 rising edges of `sck` in a readout. The first bit sampled becomes bit 7 of the address. The new address shows on `channelSel` only when the next conversion starts, and never during the readout.
- R7: `rstN` low clears everything: `channelSel` is 0 and `convActive` is low. After release, the block waits POR_CYCLES clocks before its first conversion.
- R8: While `csN` is low and the block is not reading out (during the power-on wait or a conversion), `sdo` is held at logic 1. The readout begins only after the conversion ends.
- R9: `sdoEn` is high exactly when the synchronized `csN` is low. The word shifted out is the value `resultIn` held when the conversion finished, and later changes to `resultIn` do not affect it.
- R10: If `csN` rises before 8 rising edges of `sck` have been seen, the previous channel selection is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low power-good reset |
| csN | input | 1 | Asynchronous active-low chip select |
| sck | input | 1 | Asynchronous serial clock from the host |
| sdi | input | 1 | Asynchronous serial address input |
| resultIn | input | RESULT_W | Stand-in conversion result |
| sdo | output | 1 | Serial result output |
| sdoEn | output | 1 | Output enable for `sdo` (high-impedance when low) |
| channelSel | output | ADDR_W | Channel used by the conversion in progress |
| convActive | output | 1 | High while a conversion runs |

## Verification
The assertions assume that `sck` and `sdi` change slowly compared with the system clock. Each level must last long enough to pass the synchronizers, so every `sck` edge is seen exactly once and `sdi` is settled before the rising edge that samples it. The stimulus holds each `sck` level for six clocks and changes `sdi` two clocks before each rising edge. It changes `csN` only while `sck` is low, and it raises `rstN` only while `csN` is high.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [1:0] {
    PH_POR   = 2'd0,
    PH_CONV  = 2'd1,
    PH_SLEEP = 2'd2,
    PH_OUT   = 2'd3
  } phase_e;

  typedef struct packed {
    logic loadResult;
    logic shiftOut;
    logic sampleIn;
    logic armAddr;
    logic startConv;
  } strobe_t;

endpackage

// File: rtl/adcseq_sync.sv
module adcseq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int RESULT_W    = 32,
  parameter int CONV_CYCLES = 1000,
  parameter int POR_CYCLES  = 125000,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    sck,
  input  logic    sdi,
  output logic    csHigh,
  output logic    sdiSync,
  output phase_e  phase,
  output strobe_t strobes
);
  localparam int LONGEST = (POR_CYCLES > CONV_CYCLES) ? POR_CYCLES : CONV_CYCLES;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam int BIT_W   = $clog2(RESULT_W);
  localparam logic [CNT_W-1:0] POR_LAST  = CNT_W'(POR_CYCLES - 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(RESULT_W - 1);

  logic sckSync, sckPrev, sckRise, sckFall;
  logic [CNT_W-1:0] cycleCnt;
  logic [BIT_W-1:0] bitCnt;
  logic porDone, convDone, lastFall;

  adcseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_syncCs (
    .clk(clk), .rstN(rstN), .d(csN), .q(csHigh));
  adcseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_syncSck (
    .clk(clk), .rstN(rstN), .d(sck), .q(sckSync));
  adcseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_syncSdi (
    .clk(clk), .rstN(rstN), .d(sdi), .q(sdiSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= sckSync;
  end

  assign sckRise  = sckSync & ~sckPrev;
  assign sckFall  = ~sckSync & sckPrev;
  assign porDone  = (phase == PH_POR)  && (cycleCnt == POR_LAST);
  assign convDone = (phase == PH_CONV) && (cycleCnt == CONV_LAST);
  assign lastFall = sckFall && (bitCnt == BIT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_POR;
      cycleCnt <= '0;
      bitCnt   <= '0;
    end else begin
      case (phase)
        PH_POR: begin
          if (porDone) begin
            phase    <= PH_CONV;
            cycleCnt <= '0;
          end else begin
            cycleCnt <= cycleCnt + 1'b1;
          end
        end
        PH_CONV: begin
          if (convDone) begin
            phase    <= PH_SLEEP;
            cycleCnt <= '0;
          end else begin
            cycleCnt <= cycleCnt + 1'b1;
          end
        end
        PH_SLEEP: begin
          if (!csHigh) begin
            phase  <= PH_OUT;
            bitCnt <= '0;
          end
        end
        PH_OUT: begin
          if (csHigh || lastFall) begin
            phase    <= PH_CONV;
            cycleCnt <= '0;
          end else if (sckFall) begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: phase <= PH_POR;
      endcase
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.loadResult = convDone;
    strobes.armAddr    = (phase == PH_SLEEP) && !csHigh;
    strobes.shiftOut   = (phase == PH_OUT) && !csHigh && sckFall;
    strobes.sampleIn   = (phase == PH_OUT) && !csHigh && sckRise;
    strobes.startConv  = porDone ||
                         ((phase == PH_OUT) && (csHigh || lastFall));
  end
endmodule

// File: rtl/adcseq_datapath.sv
module adcseq_datapath
  import adcseq_pkg::*;
#(
  parameter int RESULT_W = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobes,
  input  logic                outPhase,
  input  logic                sdiSync,
  input  logic [RESULT_W-1:0] resultIn,
  output logic                sdo,
  output logic [ADDR_W-1:0]   channelSel
);
  localparam int ACNT_W = $clog2(ADDR_W + 1);
  localparam logic [ACNT_W-1:0] ADDR_LAST = ACNT_W'(ADDR_W - 1);
  localparam logic [ACNT_W-1:0] ADDR_FULL = ACNT_W'(ADDR_W);

  logic [RESULT_W-1:0] shiftReg;
  logic [ADDR_W-1:0]   addrShift, pendingChan, addrNext;
  logic [ACNT_W-1:0]   addrCnt;

  assign addrNext = {addrShift[ADDR_W-2:0], sdiSync};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.loadResult) begin
      shiftReg <= resultIn;
    end else if (strobes.shiftOut) begin
      shiftReg <= {shiftReg[RESULT_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrShift   <= '0;
      addrCnt     <= '0;
      pendingChan <= '0;
    end else if (strobes.armAddr) begin
      addrCnt <= '0;
    end else if (strobes.sampleIn && (addrCnt != ADDR_FULL)) begin
      addrShift <= addrNext;
      addrCnt   <= addrCnt + 1'b1;
      if (addrCnt == ADDR_LAST) pendingChan <= addrNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  channelSel <= '0;
    else if (strobes.startConv) channelSel <= pendingChan;
  end

  assign sdo = outPhase ? shiftReg[RESULT_W-1] : 1'b1;
endmodule

// File: rtl/adc_serial_sequencer.sv
module adc_serial_sequencer
  import adcseq_pkg::*;
#(
  parameter int RESULT_W    = 32,
  parameter int ADDR_W      = 8,
  parameter int CONV_CYCLES = 1000,
  parameter int POR_CYCLES  = 125000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                sck,
  input  logic                sdi,
  input  logic [RESULT_W-1:0] resultIn,
  output logic                sdo,
  output logic                sdoEn,
  output logic [ADDR_W-1:0]   channelSel,
  output logic                convActive
);
  phase_e  phase;
  strobe_t strobes;
  logic    csHigh, sdiSync;

  adcseq_ctrl #(
    .RESULT_W(RESULT_W), .CONV_CYCLES(CONV_CYCLES),
    .POR_CYCLES(POR_CYCLES), .SYNC_STAGES(2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .sdi(sdi),
    .csHigh(csHigh), .sdiSync(sdiSync), .phase(phase), .strobes(strobes));

  adcseq_datapath #(.RESULT_W(RESULT_W), .ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .outPhase(phase == PH_OUT), .sdiSync(sdiSync), .resultIn(resultIn),
    .sdo(sdo), .channelSel(channelSel));

  assign sdoEn      = ~csHigh;
  assign convActive = (phase == PH_CONV);
endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker
  import adcseq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input phase_e            phase,
  input logic              csHigh,
  input strobe_t           strobes,
  input logic              sdo,
  input logic              sdoEn,
  input logic [ADDR_W-1:0] channelSel
);
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SLEEP && csHigh) |=> (phase == PH_SLEEP)); // R1

  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_OUT && $past(phase == PH_OUT) && !$past(strobes.shiftOut))
      |-> $stable(sdo)); // R3

  AST_ABORT_CONV: assert property (@(posedge clk) disable iff (!rstN)
    ($past(phase == PH_OUT) && $past(csHigh)) |-> (phase == PH_CONV)); // R4

  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CONV && $past(phase == PH_CONV)) |-> $stable(channelSel)); // R6

  AST_BUSY_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sdoEn && phase != PH_OUT) |-> sdo); // R8

  AST_NO_OUT_CS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ($past(phase) != PH_OUT && phase == PH_OUT) |-> $past(!csHigh)); // R2
endmodule

bind adc_serial_sequencer adcseq_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk(clk), .rstN(rstN), .phase(phase), .csHigh(csHigh),
  .strobes(strobes), .sdo(sdo), .sdoEn(sdoEn), .channelSel(channelSel));

// File: tb/test_adc_serial_sequencer.sv
`timescale 1ns/1ps
module test_adc_serial_sequencer;
  localparam int CONV = 40;
  localparam int POR  = 20;

  logic clk = 1'b0;
  logic rstN, csN, sck, sdi;
  logic [31:0] resultIn;
  logic sdo, sdoEn, convActive;
  logic [7:0] channelSel;
  int checks = 0, errors = 0;
  logic csHist0 = 1'b1, csHist1 = 1'b1;
  bit done = 0;

  always #4 clk = ~clk;

  adc_serial_sequencer #(.RESULT_W(32), .ADDR_W(8), .CONV_CYCLES(CONV), .POR_CYCLES(POR))
    i_adc_serial_sequencer (.clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .sdi(sdi),
      .resultIn(resultIn), .sdo(sdo), .sdoEn(sdoEn), .channelSel(channelSel),
      .convActive(convActive));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Behavioural per-clock model: enable tracks csN two clocks late, busy level.
  always @(posedge clk) begin
    csHist1 <= csHist0;
    csHist0 <= csN;
  end

  always @(negedge clk) begin
    if (rstN === 1'b1 && !done) begin
      check("R9 sdoEn vs delayed csN", {31'b0, sdoEn}, {31'b0, ~csHist1});
      if (sdoEn && convActive) check("R8 busy level", {31'b0, sdo}, 32'd1);
    end
  end

  task automatic waitConvEnd();
    for (int k = 0; k < 400 && convActive; k++) tick(1);
    tick(4);
  endtask

  task automatic readWord(input logic [31:0] word, input logic [7:0] addr,
                          input int nBits, input bit csLow);
    if (!csLow) begin
      csN = 1'b0;
      tick(6);
    end
    for (int i = 0; i < nBits; i++) begin
      sdi = (i < 8) ? addr[7 - i] : 1'b0;
      tick(2);
      check(i == 0 ? "R2 first bit" : "R3 bit before rise", {31'b0, sdo}, {31'b0, word[31 - i]});
      sck = 1'b1;
      tick(6);
      check("R3 bit held while sck high", {31'b0, sdo}, {31'b0, word[31 - i]});
      sck = 1'b0;
      tick(6);
    end
    if (nBits < 32) begin
      csN = 1'b1;
      tick(6);
      check("R4 abort starts conversion", {31'b0, convActive}, 32'd1);
    end else begin
      check("R5 auto conversion after 32 bits", {31'b0, convActive}, 32'd1);
      check("R8 busy after readout", {31'b0, sdo}, 32'd1);
      csN = 1'b1;
      tick(4);
    end
  endtask

  initial begin
    rstN = 1'b0; csN = 1'b1; sck = 1'b0; sdi = 1'b0;
    resultIn = 32'hA5C3_0F96;
    tick(3);
    check("R7 reset channel", {24'b0, channelSel}, 32'd0);
    check("R7 reset idle", {31'b0, convActive}, 32'd0);
    rstN = 1'b1;
    tick(POR - 5);
    check("R7 power-on wait", {31'b0, convActive}, 32'd0);
    check("R9 enable off", {31'b0, sdoEn}, 32'd0);
    tick(10);
    check("R1 conversion after wait", {31'b0, convActive}, 32'd1);
    waitConvEnd();
    tick(50);
    check("R1 sleep holds while cs high", {31'b0, convActive}, 32'd0);
    resultIn = 32'h1234_5678;
    readWord(32'hA5C3_0F96, 8'h5A, 32, 0);         // R9 captured value
    check("R6 new channel at next conversion", {24'b0, channelSel}, 32'h5A);
    waitConvEnd();
    readWord(32'h1234_5678, 8'h3C, 5, 0);
    check("R10 partial address keeps channel", {24'b0, channelSel}, 32'h5A);
    resultIn = 32'hDEAD_BEEF;
    tick(4);
    csN = 1'b0;                                    // R8 cs low during conversion
    tick(6);
    check("R8 busy during conversion", {31'b0, sdo}, 32'd1);
    check("R8 still converting", {31'b0, convActive}, 32'd1);
    waitConvEnd();
    tick(4);
    readWord(32'hDEAD_BEEF, 8'h81, 32, 1);
    check("R6 channel 0x81", {24'b0, channelSel}, 32'h81);
    tick(10);
    rstN = 1'b0;
    tick(2);
    check("R7 reset clears channel", {24'b0, channelSel}, 32'd0);
    check("R7 reset clears conversion", {31'b0, convActive}, 32'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule